// File: doc/BRIEF.md
# Quad DAC Parallel Write Sequencer

This block sits on the host side of a four-channel, 8-bit DAC that has a parallel write port. The host hands it one request at a time over a valid/ready handshake. Each request carries a 2-bit channel number and an 8-bit code. The block then drives the converter's channel-select bus, its 8-bit data bus and its active-low write strobe. It meets every minimum timing figure of that port by counting system clock cycles.

The converter's input latch is transparent for as long as the strobe is low, and it closes on the strobe's rising edge. For that reason the block drives the address and the data first, and only then pulls the strobe low. It keeps both buses unchanged through the whole low window and for a hold interval after the strobe rises. Each nanosecond limit is turned into a cycle count from a clock-period parameter. Each count is rounded up and is never less than one. The strobe stays low for the larger of the pulse-width count and the data-setup count. A shadow copy of the last code sent to each channel can be read back through a combinational port.

Top module: `dacwr_ctrl`

## Requirements
- R1: During and after a synchronous active-high reset, the strobe is high, the address and data buses are zero, ready is high and every shadow reads zero.
- R2: A request is accepted on a clock edge where both valid and ready are high. From the next cycle, the address bus carries the channel (00 = first, 01 = second, 10 = third, 11 = fourth channel), the data bus carries the code, the strobe is still high and ready is low.
- R3: The strobe falls only after the buses have been driven for the setup count, ceil(address-setup ns / clock-period ns) with a minimum of 1 cycle.
- R4: The strobe stays low for exactly the larger of ceil(pulse-width ns / period) and ceil(data-setup ns / period), each with a minimum of 1 cycle.
- R5: Address and data do not change while the strobe is low, and they stay unchanged for the hold count, ceil(data-hold ns / period) with a minimum of 1, after the strobe rises.
- R6: Ready stays low from acceptance until the hold count has elapsed. While ready is low, valid and the request payload are ignored, so writes never overlap.
- R7: On the edge where the strobe rises, the shadow entry of the addressed channel takes the code. The read port returns the shadow of the channel on the read select.
- R8: The cycle counts follow the period parameter. With a 7 ns period, 60 ns data setup, 50 ns pulse and 10 ns hold, the counts are 1 setup, 9 low and 2 hold cycles.
- R9: A level-transparent latch bank driven by the ports ends each write with the addressed channel holding the new code and the other three channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_ch | input | 2 | Target channel of the request |
| req_code | input | 8 | Code to write |
| dac_addr | output | 2 | Channel select bus to the converter |
| dac_data | output | 8 | Data bus to the converter |
| dac_wr_n | output | 1 | Write strobe, active low |
| rd_ch | input | 2 | Shadow read select |
| rd_code | output | 8 | Shadow contents of the selected channel |

## Verification
A phase register or a counter that goes wrong shows up at the ports within the same write. It appears as a strobe that falls or rises one cycle early or late, or as a ready that returns too soon. Either one shortens a measured high, low or hold window, or lets a second request disturb the buses while the latch is open. A wrong capture shows up in the next all-channel comparison against the latch model and the shadow read port. That comparison runs right after every write, so a corrupted or misrouted code is caught before the following request is issued. A second instance with an odd clock period tests the rounding and the choice of the larger low count.

// File: rtl/dacwr_pkg.sv
package dacwr_pkg;

    localparam int unsigned CH_W   = 2;
    localparam int unsigned CODE_W = 8;
    localparam int unsigned NUM_CH = 1 << CH_W;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_LOW,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic [CH_W-1:0]   ch;
        logic [CODE_W-1:0] code;
    } dac_req_t;

    // Round a nanosecond limit up to whole clock cycles, never below one.
    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned per_ns);
        int unsigned c;
        c = (ns + per_ns - 1) / per_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dacwr_timer.sv
module dacwr_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    assert_count_floor_R4: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/dacwr_seq.sv
module dacwr_seq
    import dacwr_pkg::*;
#(
    parameter int unsigned SETUP_CYC = 1,
    parameter int unsigned LOW_CYC   = 5,
    parameter int unsigned HOLD_CYC  = 1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     req_valid,
    output logic     req_ready,
    input  dac_req_t req_in,
    output dac_req_t bus_q,
    output logic     wr_n,
    output logic     commit
);
    localparam int unsigned MAXC  = max_u(max_u(SETUP_CYC, LOW_CYC), HOLD_CYC);
    localparam int unsigned CNT_W = $clog2(MAXC + 1);

    phase_e           phase;
    logic             t_load;
    logic             t_done;
    logic [CNT_W-1:0] t_val;

    dacwr_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    always_comb begin
        t_load = 1'b0;
        t_val  = '0;
        case (phase)
            PH_IDLE:  if (req_valid) begin t_load = 1'b1; t_val = CNT_W'(SETUP_CYC - 1); end
            PH_SETUP: if (t_done)    begin t_load = 1'b1; t_val = CNT_W'(LOW_CYC - 1);   end
            PH_LOW:   if (t_done)    begin t_load = 1'b1; t_val = CNT_W'(HOLD_CYC - 1);  end
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            bus_q <= '0;
            wr_n  <= 1'b1;
        end else begin
            case (phase)
                PH_IDLE: if (req_valid) begin
                    bus_q <= req_in;
                    phase <= PH_SETUP;
                end
                PH_SETUP: if (t_done) begin
                    wr_n  <= 1'b0;
                    phase <= PH_LOW;
                end
                PH_LOW: if (t_done) begin
                    wr_n  <= 1'b1;
                    phase <= PH_HOLD;
                end
                default: if (t_done) phase <= PH_IDLE;
            endcase
        end
    end

    assign req_ready = (phase == PH_IDLE);
    assign commit    = (phase == PH_LOW) && t_done;

    // Run length of the current low pulse, kept for the width check.
    logic [CNT_W:0] lo_run;
    always_ff @(posedge clk) begin
        if (rst || wr_n) lo_run <= '0;
        else             lo_run <= lo_run + 1'b1;
    end

    assert_strobe_width_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_n) |-> (lo_run == (CNT_W+1)'(LOW_CYC)));
    assert_setup_before_fall_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_n) |-> $stable(bus_q));
    assert_bus_frozen_low_R5: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && $past(!wr_n)) |-> $stable(bus_q));
    assert_bus_hold_after_rise_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_n) |=> $stable(bus_q));
endmodule

// File: rtl/dacwr_shadow.sv
module dacwr_shadow
    import dacwr_pkg::*;
#(
    parameter bit SHADOW_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [CODE_W-1:0] wr_code,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [CODE_W-1:0] rd_code
);
    generate
        if (SHADOW_EN) begin : g_shadow
            logic [CODE_W-1:0] mem [NUM_CH];

            for (genvar i = 0; i < NUM_CH; i++) begin : g_ent
                always_ff @(posedge clk) begin
                    if (rst)                                   mem[i] <= '0;
                    else if (commit && wr_ch == CH_W'(i))      mem[i] <= wr_code;
                end
            end

            assign rd_code = mem[rd_ch];

            assert_shadow_capture_R7: assert property (@(posedge clk) disable iff (rst)
                commit |=> (mem[$past(wr_ch)] == $past(wr_code)));
        end else begin : g_none
            assign rd_code = '0;
            wire unused_shadow = ^{clk, rst, commit, wr_ch, wr_code, rd_ch};
        end
    endgenerate
endmodule

// File: rtl/dacwr_ctrl.sv
module dacwr_ctrl
    import dacwr_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned ADDR_SETUP_NS = 0,
    parameter int unsigned DATA_SETUP_NS = 45,
    parameter int unsigned STROBE_LOW_NS = 50,
    parameter int unsigned DATA_HOLD_NS  = 10,
    parameter bit          SHADOW_EN     = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CH_W-1:0]   req_ch,
    input  logic [CODE_W-1:0] req_code,
    output logic [CH_W-1:0]   dac_addr,
    output logic [CODE_W-1:0] dac_data,
    output logic              dac_wr_n,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [CODE_W-1:0] rd_code
);
    localparam int unsigned SETUP_CYC = ns_to_cyc(ADDR_SETUP_NS, CLK_PERIOD_NS);
    localparam int unsigned LOW_CYC   = max_u(ns_to_cyc(STROBE_LOW_NS, CLK_PERIOD_NS),
                                              ns_to_cyc(DATA_SETUP_NS, CLK_PERIOD_NS));
    localparam int unsigned HOLD_CYC  = ns_to_cyc(DATA_HOLD_NS, CLK_PERIOD_NS);

    dac_req_t req_in;
    dac_req_t bus_q;
    logic     commit;

    assign req_in = '{ch: req_ch, code: req_code};

    dacwr_seq #(
        .SETUP_CYC (SETUP_CYC),
        .LOW_CYC   (LOW_CYC),
        .HOLD_CYC  (HOLD_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_in    (req_in),
        .bus_q     (bus_q),
        .wr_n      (dac_wr_n),
        .commit    (commit)
    );

    dacwr_shadow #(.SHADOW_EN(SHADOW_EN)) u_shadow (
        .clk     (clk),
        .rst     (rst),
        .commit  (commit),
        .wr_ch   (bus_q.ch),
        .wr_code (bus_q.code),
        .rd_ch   (rd_ch),
        .rd_code (rd_code)
    );

    assign dac_addr = bus_q.ch;
    assign dac_data = bus_q.code;

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dac_wr_n && req_ready && dac_addr == '0 && dac_data == '0));
    assert_busy_after_accept_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);
    assert_no_ready_while_open_R6: assert property (@(posedge clk) disable iff (rst)
        !dac_wr_n |-> !req_ready);
    assert_accept_drives_bus_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (dac_addr == $past(req_ch) && dac_data == $past(req_code) && dac_wr_n));
endmodule

// File: tb/dacwr_ctrl_test.sv
module dacwr_ctrl_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit done_flag = 0;

    logic       v = 1'b0;
    bit         sel = 1'b0;
    logic [1:0] req_ch = '0;
    logic [7:0] req_code = '0;
    logic [1:0] rd_ch = '0;

    logic       rdy1, rdy2, wr1, wr2;
    logic [1:0] ad1, ad2;
    logic [7:0] da1, da2, rc1, rc2;

    dacwr_ctrl uut (
        .clk(clk), .rst(rst), .req_valid(v & ~sel), .req_ready(rdy1),
        .req_ch(req_ch), .req_code(req_code), .dac_addr(ad1), .dac_data(da1),
        .dac_wr_n(wr1), .rd_ch(rd_ch), .rd_code(rc1));

    dacwr_ctrl #(.CLK_PERIOD_NS(7), .DATA_SETUP_NS(60)) uut2 (
        .clk(clk), .rst(rst), .req_valid(v & sel), .req_ready(rdy2),
        .req_ch(req_ch), .req_code(req_code), .dac_addr(ad2), .dac_data(da2),
        .dac_wr_n(wr2), .rd_ch(rd_ch), .rd_code(rc2));

    function automatic int cyc(int ns, int per);
        int c = (ns + per - 1) / per;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(int a, int b);
        return (a > b) ? a : b;
    endfunction

    int eS [2];
    int eL [2];
    int eH [2];

    wire       m_rdy  = sel ? rdy2 : rdy1;
    wire       m_wr   = sel ? wr2 : wr1;
    wire [1:0] m_ad   = sel ? ad2 : ad1;
    wire [7:0] m_da   = sel ? da2 : da1;
    wire [7:0] m_rc   = sel ? rc2 : rc1;

    // Level-transparent latch bank models, one per instance.
    logic [7:0] lat1 [4];
    logic [7:0] lat2 [4];
    logic [7:0] exp_l [2][4];
    initial for (int i = 0; i < 4; i++) begin lat1[i] = '0; lat2[i] = '0; end
    always @(negedge clk) if (!rst && !wr1) lat1[ad1] = da1;
    always @(negedge clk) if (!rst && !wr2) lat2[ad2] = da2;

    // Bus stability monitor across the strobe window and the hold interval.
    int viol = 0;
    int since_rise = 100;
    logic       p_wr = 1'b1;
    logic [1:0] p_ad = '0;
    logic [7:0] p_da = '0;
    bit         p_sel = 1'b0;
    always @(negedge clk) begin
        if (!rst && p_sel == sel) begin
            if ((m_ad != p_ad || m_da != p_da) && (!m_wr || !p_wr || since_rise < eH[sel]))
                viol++;
            if (m_wr && !p_wr) since_rise = 0;
            else if (since_rise < 100) since_rise++;
        end
        p_wr = m_wr; p_ad = m_ad; p_da = m_da; p_sel = sel;
    end

    task automatic chk(string req, int act, int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic check_all();
        for (int k = 0; k < 4; k++) begin
            rd_ch = k[1:0];
            #1;
            chk("R9 latch", sel ? lat2[k] : lat1[k], exp_l[sel][k]);
            chk("R7 shadow", m_rc, exp_l[sel][k]);
        end
    endtask

    task automatic do_write(input logic [1:0] ch, input logic [7:0] code);
        int hi, lo, hd;
        @(negedge clk);
        v = 1'b1; req_ch = ch; req_code = code;
        while (!m_rdy) @(negedge clk);
        @(negedge clk);
        chk("R2 addr", m_ad, ch);
        chk("R2 data", m_da, code);
        chk("R2 strobe high", m_wr, 1);
        chk("R6 ready low", m_rdy, 0);
        req_ch = ~ch; req_code = ~code;            // ignored while busy (R6)
        hi = 1;
        forever begin @(negedge clk); if (!m_wr) break; hi++; end
        chk("R3 setup cycles", hi, eS[sel]);
        lo = 1;
        forever begin @(negedge clk); if (m_wr) break; lo++; end
        chk(sel ? "R4 R8 low cycles" : "R4 low cycles", lo, eL[sel]);
        chk("R5 data at rise", m_da, code);
        hd = 1;
        forever begin @(negedge clk); if (m_rdy) break; hd++; end
        v = 1'b0;
        chk(sel ? "R6 R8 hold cycles" : "R6 hold cycles", hd, eH[sel]);
        chk("R5 addr after hold", m_ad, ch);
        exp_l[sel][ch] = code;
        check_all();
    endtask

    initial begin
        eS[0] = cyc(0, 10); eL[0] = mx(cyc(50, 10), cyc(45, 10)); eH[0] = cyc(10, 10);
        eS[1] = cyc(0, 7);  eL[1] = mx(cyc(50, 7), cyc(60, 7));   eH[1] = cyc(10, 7);
        for (int w = 0; w < 2; w++) for (int k = 0; k < 4; k++) exp_l[w][k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 strobe", wr1, 1);
        chk("R1 ready", rdy1, 1);
        chk("R1 addr", ad1, 0);
        chk("R1 data", da1, 0);
        for (int k = 0; k < 4; k++) begin
            rd_ch = k[1:0]; #1;
            chk("R1 shadow", rc1, 0);
            chk("R1 shadow inst2", rc2, 0);
        end
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", {wr1, rdy1, wr2, rdy2}, 4'hF);
        for (int s = 0; s < 2; s++) begin
            sel = s[0];
            repeat (2) @(negedge clk);
            for (int ch = 0; ch < 4; ch++) do_write(ch[1:0], 8'(ch * 61 + 19));
            for (int ch = 3; ch >= 0; ch--) do_write(ch[1:0], 8'hFF);
            for (int ch = 0; ch < 4; ch++) do_write(ch[1:0], 8'h00);
            do_write(2'd2, 8'hA5);
            do_write(2'd2, 8'h5A);
        end
        repeat (3) @(negedge clk);
        chk("R5 R6 bus stable in window", viol, 0);
        done_flag = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule